// File: doc/BRIEF.md
# Real-Time Clock with Alarm and Periodic Interrupts

This block keeps wall-clock time as a day count plus hours, minutes and seconds. It advances from a slow reference that arrives as a single-cycle enable pulse inside the system clock domain. A prescaler divides that reference down to a one-second tick. The divisor is chosen by software from three nominal reference rates. The same prescaler splits each second into 512 equal steps, and from these it derives event pulses at every power-of-two rate from 2 Hz to 512 Hz.

Software reaches the block through a 16-bit register port with byte addresses. It sets the time and an alarm instant, starts or stops counting, and reads the time back. Events latch into a sticky status register, which is cleared by writing ones. An enable mask selects which latched events drive the single interrupt line. A time write takes effect at once and restarts the current second, so software can realign the clock without a race against a carry.

Top module: `rtc_core`

## Requirements
- R1: After reset every register described below reads zero and `irq` is low.
- R2: Register byte addresses: 0x00 hour/minute (hour in bits 12:8, minute in bits 5:0), 0x04 seconds (bits 5:0), 0x08 alarm hour/minute (same packing), 0x0C alarm seconds, 0x10 control, 0x14 status, 0x18 enable, 0x20 day (16 bits), 0x24 alarm day. A written value reads back with unused bits as zero, and any other address reads zero.
- R3: Control bit 7 is the run enable and bits 6:5 pick the divisor: 00 = 32768, 01 = 32000, 10 = 38400, 11 behaves as 00. Both fields read back as written.
- R4: While running, seconds advance after exactly one divisor's worth of counted reference pulses, and status bit 4 sets on that tick.
- R5: Periodic events use status bits 7 (2 Hz) through 15 (512 Hz), in rising order of rate. The first 512 Hz event after a restart lands on counted reference pulse ceil(divisor/512), which is 64, 63 and 75 for the three divisors. Every periodic event fires together with the one-second tick.
- R6: Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0 and carry into the day count, which wraps from 65535 to 0.
- R7: Status bit 2 sets on the tick whose new day, hour, minute and second all equal the alarm registers.
- R8: Writing the status register clears each bit written as 1 and leaves each bit written as 0. An event arriving in the same cycle wins over the clear.
- R9: Status bits set on their events whatever the enable mask holds. Only bits 2, 4 and 7 to 15 of status and enable are implemented (mask 0xFF94).
- R10: `irq` is high exactly when some bit is set in both status and enable.
- R11: A write to the hour/minute, seconds or day register loads that value in the same cycle and restarts the sub-second count, so the next tick follows a full divisor of counted pulses.
- R12: While bit 7 of control is 0, reference pulses are ignored and the time and the sub-second count hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address for reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle the local cause-and-effect rules. These are the seconds wrap on a tick, the hold while stopped, the prescaler restart after a time write, the latch of the tick into status, a status clear with no event racing it, the alarm bit rising only on an alarm match, and all periodic pulses coinciding with the tick. Only the bench scenarios can show the absolute timing: the exact count of reference pulses to the first 512 Hz event for each divisor, the full second of 32768 pulses, the multi-field rollover from the last day back to day zero, and the alarm firing on the intended second. Register packing, the implemented-bit mask and the interrupt combination are exercised by seeded random register traffic against a bench model.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 6;
    localparam int DAY_W      = 16;
    localparam int STEP_LOG2  = 9;                 // 512 sub-second steps
    localparam int NUM_RATES  = STEP_LOG2;         // 2 Hz .. 512 Hz
    localparam int ACC_W      = 17;

    localparam logic [5:0] SEC_LAST  = 6'd59;
    localparam logic [5:0] MIN_LAST  = 6'd59;
    localparam logic [4:0] HOUR_LAST = 5'd23;

    localparam logic [ADDR_W-1:0] OFS_HM    = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_SEC   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_AHM   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_ASEC  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_EN    = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_DAY   = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_ADAY  = 6'h24;

    localparam int BIT_ALARM  = 2;
    localparam int BIT_SEC    = 4;
    localparam int BIT_RATE0  = 7;                 // 2 Hz, then one bit per doubling
    localparam int CTRL_RUN   = 7;

    localparam logic [DATA_W-1:0] EVT_MASK = 16'hFF94;

    typedef enum logic [1:0] {
        REF_32768 = 2'b00,
        REF_32000 = 2'b01,
        REF_38400 = 2'b10,
        REF_SPARE = 2'b11
    } ref_sel_e;

    typedef struct packed {
        logic [DAY_W-1:0] day;
        logic [4:0]       hour;
        logic [5:0]       min;
        logic [5:0]       sec;
    } tod_t;

    function automatic logic [ACC_W-1:0] ref_divisor(input ref_sel_e sel);
        case (sel)
            REF_32000: return ACC_W'(32000);
            REF_38400: return ACC_W'(38400);
            default:   return ACC_W'(32768);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_hm(input logic [4:0] h, input logic [5:0] m);
        return {3'b000, h, 2'b00, m};
    endfunction

    function automatic tod_t tod_advance(input tod_t t);
        tod_t n;
        n = t;
        if (t.sec == SEC_LAST) begin
            n.sec = '0;
            if (t.min == MIN_LAST) begin
                n.min = '0;
                if (t.hour == HOUR_LAST) begin
                    n.hour = '0;
                    n.day  = t.day + 1'b1;
                end else begin
                    n.hour = t.hour + 1'b1;
                end
            end else begin
                n.min = t.min + 1'b1;
            end
        end else begin
            n.sec = t.sec + 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int STEPS_LOG2 = STEP_LOG2,
    parameter int AW         = ACC_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic                  ref_tick,
    input  logic                  restart,
    input  logic [AW-1:0]         divisor,
    output logic                  sec_pulse,
    output logic [STEPS_LOG2-1:0] rate_pulse,
    output logic [STEPS_LOG2-1:0] step
);
    localparam logic [AW-1:0] STEP_INC = AW'(1) << STEPS_LOG2;

    logic [AW-1:0]         acc_q;
    logic [AW-1:0]         acc_sum;
    logic [STEPS_LOG2-1:0] step_q;
    logic [STEPS_LOG2-1:0] step_nxt;
    logic                  counting;
    logic                  advance;

    assign counting = run && ref_tick && !restart;
    assign acc_sum  = acc_q + STEP_INC;
    assign advance  = counting && (acc_sum >= divisor);
    assign step_nxt = step_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            acc_q  <= '0;
            step_q <= '0;
        end else if (counting) begin
            acc_q <= advance ? (acc_sum - divisor) : acc_sum;
            if (advance) step_q <= step_nxt;
        end
    end

    assign sec_pulse = advance && (step_nxt == '0);
    assign step      = step_q;

    // rate_pulse[k] is the 2^(k+1) Hz event: every 2^(STEPS_LOG2-1-k) steps
    for (genvar k = 0; k < STEPS_LOG2; k++) begin : g_rate
        if (k == STEPS_LOG2 - 1) begin : g_every
            assign rate_pulse[k] = advance;
        end else begin : g_div
            assign rate_pulse[k] = advance && (step_nxt[STEPS_LOG2-2-k:0] == '0);
        end
    end

endmodule

// File: rtl/rtc_timekeeper.sv
`timescale 1ns/1ps
module rtc_timekeeper
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_pulse,
    input  logic              wr_hm,
    input  logic              wr_sec,
    input  logic              wr_day,
    input  logic              wr_ahm,
    input  logic              wr_asec,
    input  logic              wr_aday,
    input  logic [DATA_W-1:0] wdata,
    output tod_t              now,
    output tod_t              alarm,
    output logic              alarm_hit
);
    tod_t now_q;
    tod_t alm_q;
    tod_t now_nxt;

    assign now_nxt   = tod_advance(now_q);
    assign alarm_hit = sec_pulse && (now_nxt == alm_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q <= '0;
            alm_q <= '0;
        end else begin
            if (sec_pulse) now_q <= now_nxt;
            if (wr_hm) begin
                now_q.hour <= wdata[12:8];
                now_q.min  <= wdata[5:0];
            end
            if (wr_sec) now_q.sec <= wdata[5:0];
            if (wr_day) now_q.day <= wdata[DAY_W-1:0];
            if (wr_ahm) begin
                alm_q.hour <= wdata[12:8];
                alm_q.min  <= wdata[5:0];
            end
            if (wr_asec) alm_q.sec <= wdata[5:0];
            if (wr_aday) alm_q.day <= wdata[DAY_W-1:0];
        end
    end

    assign now   = now_q;
    assign alarm = alm_q;

endmodule

// File: rtl/rtc_irq_ctrl.sv
`timescale 1ns/1ps
module rtc_irq_ctrl
    import rtc_pkg::*;
#(
    parameter logic [DATA_W-1:0] MASK = EVT_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] set_vec,
    input  logic              clr_we,
    input  logic              en_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] enable,
    output logic              irq
);
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] clr_vec;

    assign clr_vec = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= ((stat_q & ~clr_vec) | set_vec) & MASK;
            if (en_we) en_q <= wdata & MASK;
        end
    end

    assign status = stat_q;
    assign enable = en_q;
    assign irq    = |(stat_q & en_q);

endmodule

// File: rtl/rtc_core.sv
`timescale 1ns/1ps
module rtc_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic              ctrl_run;
    ref_sel_e          ctrl_sel;
    logic              wr_hm, wr_sec, wr_day, wr_ahm, wr_asec, wr_aday;
    logic              wr_ctrl, wr_stat, wr_en;
    logic              time_wr;
    logic              sec_pulse;
    logic [NUM_RATES-1:0] rate_pulse;
    logic [STEP_LOG2-1:0] presc_step;
    logic              alarm_hit;
    tod_t              tod_now;
    tod_t              tod_alarm;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] en_q;

    assign wr_hm   = reg_we && (reg_addr == OFS_HM);
    assign wr_sec  = reg_we && (reg_addr == OFS_SEC);
    assign wr_day  = reg_we && (reg_addr == OFS_DAY);
    assign wr_ahm  = reg_we && (reg_addr == OFS_AHM);
    assign wr_asec = reg_we && (reg_addr == OFS_ASEC);
    assign wr_aday = reg_we && (reg_addr == OFS_ADAY);
    assign wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
    assign wr_stat = reg_we && (reg_addr == OFS_STAT);
    assign wr_en   = reg_we && (reg_addr == OFS_EN);
    assign time_wr = wr_hm || wr_sec || wr_day;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_run <= 1'b0;
            ctrl_sel <= REF_32768;
        end else if (wr_ctrl) begin
            ctrl_run <= reg_wdata[CTRL_RUN];
            ctrl_sel <= ref_sel_e'(reg_wdata[6:5]);
        end
    end

    rtc_prescaler #(
        .STEPS_LOG2 (STEP_LOG2),
        .AW         (ACC_W)
    ) u_presc (
        .clk        (clk),
        .rst        (rst),
        .run        (ctrl_run),
        .ref_tick   (ref_tick),
        .restart    (time_wr),
        .divisor    (ref_divisor(ctrl_sel)),
        .sec_pulse  (sec_pulse),
        .rate_pulse (rate_pulse),
        .step       (presc_step)
    );

    rtc_timekeeper u_time (
        .clk       (clk),
        .rst       (rst),
        .sec_pulse (sec_pulse),
        .wr_hm     (wr_hm),
        .wr_sec    (wr_sec),
        .wr_day    (wr_day),
        .wr_ahm    (wr_ahm),
        .wr_asec   (wr_asec),
        .wr_aday   (wr_aday),
        .wdata     (reg_wdata),
        .now       (tod_now),
        .alarm     (tod_alarm),
        .alarm_hit (alarm_hit)
    );

    always_comb begin
        set_vec = '0;
        set_vec[BIT_ALARM] = alarm_hit;
        set_vec[BIT_SEC]   = sec_pulse;
        set_vec[BIT_RATE0 +: NUM_RATES] = rate_pulse;
    end

    rtc_irq_ctrl #(
        .MASK (EVT_MASK)
    ) u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_we  (wr_stat),
        .en_we   (wr_en),
        .wdata   (reg_wdata),
        .status  (stat_q),
        .enable  (en_q),
        .irq     (irq)
    );

    always_comb begin
        case (reg_addr)
            OFS_HM:   reg_rdata = pack_hm(tod_now.hour, tod_now.min);
            OFS_SEC:  reg_rdata = {10'd0, tod_now.sec};
            OFS_AHM:  reg_rdata = pack_hm(tod_alarm.hour, tod_alarm.min);
            OFS_ASEC: reg_rdata = {10'd0, tod_alarm.sec};
            OFS_CTRL: reg_rdata = {8'd0, ctrl_run, ctrl_sel, 5'd0};
            OFS_STAT: reg_rdata = stat_q;
            OFS_EN:   reg_rdata = en_q;
            OFS_DAY:  reg_rdata = tod_now.day;
            OFS_ADAY: reg_rdata = tod_alarm.day;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_core_checker.sv
`timescale 1ns/1ps
module rtc_core_checker
    import rtc_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 run,
    input logic                 time_wr,
    input logic                 sec_pulse,
    input logic [NUM_RATES-1:0] rate_pulse,
    input logic                 alarm_hit,
    input logic [STEP_LOG2-1:0] step,
    input tod_t                 now,
    input logic [DATA_W-1:0]    status,
    input logic                 stat_wr,
    input logic                 clr_sec_bit
);

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (sec_pulse && !time_wr && now.sec == SEC_LAST) |=> (now.sec == '0)); // R6

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!run && !time_wr) |=> ($stable(now) && $stable(step))); // R12

    AST_RESTART_STEP: assert property (@(posedge clk) disable iff (rst)
        time_wr |=> (step == '0)); // R11

    AST_TICK_LATCH: assert property (@(posedge clk) disable iff (rst)
        sec_pulse |=> status[BIT_SEC]); // R4

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && clr_sec_bit && !sec_pulse) |=> !status[BIT_SEC]); // R8

    AST_ALARM_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(status[BIT_ALARM]) |-> $past(alarm_hit)); // R7

    AST_RATES_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        sec_pulse |-> (&rate_pulse)); // R5

endmodule

bind rtc_core rtc_core_checker u_rtc_core_checker (
    .clk         (clk),
    .rst         (rst),
    .run         (ctrl_run),
    .time_wr     (time_wr),
    .sec_pulse   (sec_pulse),
    .rate_pulse  (rate_pulse),
    .alarm_hit   (alarm_hit),
    .step        (presc_step),
    .now         (tod_now),
    .status      (stat_q),
    .stat_wr     (wr_stat),
    .clr_sec_bit (reg_wdata[4])
);

// File: tb/rtc_core_bench.sv
`timescale 1ns/1ps
module rtc_core_bench;

    localparam logic [5:0] A_HM = 6'h00, A_SEC = 6'h04, A_AHM = 6'h08, A_ASEC = 6'h0C,
                           A_CTRL = 6'h10, A_STAT = 6'h14, A_EN = 6'h18, A_DAY = 6'h20,
                           A_ADAY = 6'h24;
    localparam logic [15:0] IMPL = 16'hFF94;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b1;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rtc_core u_rtc_core (
        .clk       (clk),
        .rst       (rst),
        .ref_tick  (ref_tick),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] v);
        reg_addr = a;
        #0.1;
        v = reg_rdata;
    endtask

    // bench model of one second of time advance
    function automatic logic [32:0] next_tod(input logic [32:0] t);
        logic [15:0] d; logic [4:0] h; logic [5:0] m; logic [5:0] s;
        {d, h, m, s} = t;
        if (s == 59) begin
            s = 0;
            if (m == 59) begin
                m = 0;
                if (h == 23) begin h = 0; d = d + 16'd1; end
                else h = h + 5'd1;
            end else m = m + 6'd1;
        end else s = s + 6'd1;
        return {d, h, m, s};
    endfunction

    function automatic logic [15:0] hm(input logic [4:0] h, input logic [5:0] m);
        return {3'b0, h, 2'b0, m};
    endfunction

    // first 512 Hz event lands on counted pulse n_first; only bit 15 set then
    task automatic rate_probe(input logic [1:0] sel, input int n_first, input string tag);
        logic [15:0] v;
        wr(A_CTRL, {8'd0, 1'b0, sel, 5'd0});
        wr(A_SEC, 16'd0);
        wr(A_STAT, 16'hFFFF);
        rd(A_STAT, v);
        check("R8 status cleared", v, 16'h0000);
        wr(A_CTRL, {8'd0, 1'b1, sel, 5'd0});
        repeat (n_first - 1) @(posedge clk);
        #1;
        rd(A_STAT, v);
        check({"R5 no 512Hz yet ", tag}, v, 16'h0000);
        @(posedge clk);
        #1;
        rd(A_STAT, v);
        check({"R5 first 512Hz only ", tag}, v, 16'h8000);
        check({"R9 status set with mask 0, irq low ", tag}, {15'd0, irq}, 16'h0000);
    endtask

    initial begin : main
        logic [15:0] v;
        logic [32:0] exp_t;
        logic [15:0] m_st, m_en;
        int unsigned seed;
        seed = 32'h00C0FFEE;
        v = 16'($urandom(seed));

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;

        // R1 reset values
        foreach (u_dummy_addrs[i]) begin
            rd(u_dummy_addrs[i], v);
            check("R1 reset register", v, 16'h0000);
        end
        check("R1 reset irq", {15'd0, irq}, 16'h0000);

        // R2 / R3 register packing and control readback
        wr(A_AHM, 16'hFFFF);
        rd(A_AHM, v); check("R2 alarm hm packing", v, 16'h1F3F);
        wr(A_ASEC, 16'hFFC5);
        rd(A_ASEC, v); check("R2 alarm sec width", v, 16'h0005);
        rd(6'h1C, v);  check("R2 unmapped reads zero", v, 16'h0000);
        wr(A_CTRL, 16'hFFFF);
        rd(A_CTRL, v); check("R3 control readback", v, 16'h00E0);
        wr(A_CTRL, 16'h0000);

        // R5 / R3 first periodic event per divisor, R12 hold while stopped
        rate_probe(2'b01, 63, "div32000");
        rate_probe(2'b10, 75, "div38400");
        rate_probe(2'b11, 64, "sel11");
        wr(A_CTRL, 16'h0000);
        wr(A_STAT, 16'hFFFF);
        repeat (300) @(posedge clk);
        #1;
        rd(A_STAT, v); check("R12 no events while stopped", v, 16'h0000);

        // R4 / R6 one-second period and full rollover from the last day
        wr(A_DAY, 16'hFFFF);
        wr(A_HM, hm(5'd23, 6'd59));
        wr(A_SEC, 16'd58);
        wr(A_STAT, 16'hFFFF);
        wr(A_CTRL, 16'h0080);
        exp_t = {16'hFFFF, 5'd23, 6'd59, 6'd58};
        repeat (32767) @(posedge clk);
        #1;
        rd(A_SEC, v); check("R4 seconds before full divisor", v, 16'd58);
        @(posedge clk);
        #1;
        exp_t = next_tod(exp_t);
        rd(A_SEC, v);  check("R4 seconds after 32768 pulses", v, {10'd0, exp_t[5:0]});
        rd(A_STAT, v); check("R4 tick status bit 4", v & 16'h0010, 16'h0010);
        check("R5 all periodic bits with tick", v & 16'hFF80, 16'hFF80);
        repeat (32767) @(posedge clk);
        #1;
        rd(A_SEC, v); check("R6 still 59", v, 16'd59);
        @(posedge clk);
        #1;
        exp_t = next_tod(exp_t);
        rd(A_SEC, v); check("R6 seconds wrap", v, {10'd0, exp_t[5:0]});
        rd(A_HM, v);  check("R6 hour/minute wrap", v, hm(exp_t[16:12], exp_t[11:6]));
        rd(A_DAY, v); check("R6 day wraps to zero", v, exp_t[32:17]);

        // R7 / R11 alarm at 32000 with a restarting time write
        wr(A_CTRL, 16'h00A0);
        wr(A_ADAY, 16'd2);
        wr(A_AHM, hm(5'd10, 6'd20));
        wr(A_ASEC, 16'd31);
        wr(A_DAY, 16'd2);
        wr(A_HM, hm(5'd10, 6'd20));
        wr(A_STAT, 16'hFFFF);
        wr(A_SEC, 16'd30);
        repeat (31999) @(posedge clk);
        #1;
        rd(A_SEC, v);  check("R11 write restarted the second", v, 16'd30);
        rd(A_STAT, v); check("R7 no alarm before match", v & 16'h0004, 16'h0000);
        @(posedge clk);
        #1;
        rd(A_SEC, v);  check("R11 tick after full divisor", v, 16'd31);
        rd(A_STAT, v); check("R7 alarm on match", v & 16'h0004, 16'h0004);
        check("R9 alarm latched with mask 0, irq low", {15'd0, irq}, 16'h0000);
        wr(A_CTRL, 16'h0020);
        wr(A_EN, 16'h0004);
        #0.5;
        check("R10 irq from enabled alarm", {15'd0, irq}, 16'h0001);
        wr(A_STAT, 16'h0004);
        #0.5;
        rd(A_STAT, v);
        check("R8 alarm bit cleared", v & 16'h0004, 16'h0000);
        check("R8 tick bit untouched by 0", v & 16'h0010, 16'h0010);
        check("R10 irq drops after clear", {15'd0, irq}, 16'h0000);

        // seeded random register traffic while stopped
        rd(A_STAT, m_st);
        m_en = 16'h0004;
        for (int i = 0; i < 60; i++) begin
            logic [15:0] d;
            logic [4:0] h; logic [5:0] mi;
            int op;
            op = int'($urandom % 6);
            d  = 16'($urandom);
            h  = 5'($urandom % 24);
            mi = 6'($urandom % 60);
            case (op)
                0: begin wr(A_HM, {3'b111, h, 2'b11, mi}); rd(A_HM, v);
                         check("R2 random hm", v, hm(h, mi)); end
                1: begin wr(A_SEC, {10'h3FF, mi}); rd(A_SEC, v);
                         check("R2 random seconds", v, {10'd0, mi}); end
                2: begin wr(A_DAY, d); rd(A_DAY, v);
                         check("R2 random day", v, d); end
                3: begin wr(A_AHM, hm(h, mi)); rd(A_AHM, v);
                         check("R2 random alarm hm", v, hm(h, mi)); end
                4: begin wr(A_EN, d); m_en = d & IMPL; rd(A_EN, v);
                         check("R9 enable implemented bits", v, m_en); end
                default: begin wr(A_STAT, d); m_st = m_st & ~d; rd(A_STAT, v);
                         check("R8 random write-one-clear", v, m_st); end
            endcase
            check("R10 irq vs model", {15'd0, irq}, {15'd0, |(m_st & m_en)});
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    logic [5:0] u_dummy_addrs [9] = '{A_HM, A_SEC, A_AHM, A_ASEC, A_CTRL, A_STAT, A_EN, A_DAY, A_ADAY};

    initial begin : watchdog
        #780000;
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule